// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a watchdog counter that advances on a slow timing tick and asks for a processor reset if software stops servicing it. Software keeps it alive by writing a key byte to the control register. Only four byte values count as keys. Each key clears the count and also chooses the timeout period, so a single write both services the watchdog and sets how long the next interval lasts. Every other byte written to the control register is ignored.

When the count reaches the terminal value for the chosen period, the block raises a reset request for one fast-clock cycle. It also holds a watchdog output high until the next slow tick, so that output lasts one tick. The counter then starts again from zero with the same period. A watchdog-caused reset leaves the chosen period unchanged, because only the block's own power-on reset restores the default.

A second register is for test. Some of its codes let the fast clock drive the lower or upper part of the counter, which shortens long intervals. The same register can stop the watchdog, but only through an ordered pair of writes.

Top module: `keyed_wdt`

## Requirements
- R1: After power-on reset the period is 2 s (65536 ticks), the clock source is the slow tick, the watchdog is enabled, the count is zero, and `wdt_pulse` and `rst_req` are low.
- R2: A control write of 0x53, 0x59, 0x57 or 0x5A clears the count and sets the terminal count to 8192, 16384, 32768 or 65536 ticks respectively (250 ms, 500 ms, 1 s, 2 s at 32.768 kHz).
- R3: A control write of any other byte leaves the count and the period unchanged.
- R4: When an advance would bring the count to the terminal value or beyond it, `rst_req` is high for exactly one clock cycle. The count returns to zero and keeps the same period, so the next timeout follows one full period later.
- R5: `wdt_pulse` rises in the same cycle as `rst_req`. It stays high until the clock edge at which `slow_tick` is next sampled high.
- R6: The count is 17 bits, split into bits 7:0 (lower) and bits 16:8 (upper). Test code 0x51 advances the lower part on every clock, with a carry into the upper part. Code 0x52 advances the upper part on every clock, while the lower part follows `slow_tick`. Code 0x53 advances both parts on every clock, with no carry between them.
- R7: Every other test code selects normal clocking: the lower part advances on `slow_tick`, and the upper part advances on `slow_tick` when the lower part is 0xFF. With `slow_tick` low, the count does not move.
- R8: A test write of 0x54 stops the watchdog only if the test write just before it was 0x51, 0x52 or 0x53. While stopped, the count holds and no timeout occurs, but a key write still clears the count.
- R9: Any test write other than 0x54 restarts a stopped watchdog.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast peripheral clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| slow_tick | input | 1 | One-cycle enable marking each slow (32.768 kHz) tick |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Register select: 0 control (keys), 1 test |
| wr_data | input | 8 | Write data byte |
| wdt_pulse | output | 1 | Watchdog output, high for one slow tick after timeout |
| rst_req | output | 1 | One-cycle processor reset request |

## Verification
The embedded properties check the invariants on every cycle. The count stays below the active terminal. A reset request lasts one cycle and comes with the watchdog output. A key write clears the count. A non-key write leaves the period unchanged. A stopped counter holds still. The stopped state is entered only straight after an arming code and is left on any other test write. The actual timeout intervals for each key under each clock source, the width of the watchdog output measured in slow ticks, and the ordering rules of the unlock sequence can only be shown by the bench scenarios, which count clock edges from a key write to the reset request.

// File: rtl/keyed_wdt_pkg.sv
package keyed_wdt_pkg;

    // Period selector; terminal count is BASE << period
    typedef enum logic [1:0] {
        PER_250MS = 2'd0,
        PER_500MS = 2'd1,
        PER_1S    = 2'd2,
        PER_2S    = 2'd3
    } period_e;

    // Counter clock source selected by the test register
    typedef enum logic [1:0] {
        SRC_SLOW      = 2'd0,
        SRC_FAST_LO   = 2'd1,
        SRC_FAST_HI   = 2'd2,
        SRC_FAST_BOTH = 2'd3
    } src_e;

    typedef struct packed {
        logic    hit;
        period_e period;
    } key_dec_t;

    localparam logic [7:0] KEY_250MS = 8'h53;
    localparam logic [7:0] KEY_500MS = 8'h59;
    localparam logic [7:0] KEY_1S    = 8'h57;
    localparam logic [7:0] KEY_2S    = 8'h5A;

    localparam logic [7:0] TST_LO   = 8'h51;
    localparam logic [7:0] TST_HI   = 8'h52;
    localparam logic [7:0] TST_BOTH = 8'h53;
    localparam logic [7:0] TST_OFF  = 8'h54;

    function automatic key_dec_t decode_key(input logic [7:0] b);
        key_dec_t d;
        d.hit    = 1'b1;
        d.period = PER_2S;
        unique case (b)
            KEY_250MS: d.period = PER_250MS;
            KEY_500MS: d.period = PER_500MS;
            KEY_1S:    d.period = PER_1S;
            KEY_2S:    d.period = PER_2S;
            default:   d.hit    = 1'b0;
        endcase
        return d;
    endfunction

    function automatic src_e decode_src(input logic [7:0] b);
        unique case (b)
            TST_LO:   return SRC_FAST_LO;
            TST_HI:   return SRC_FAST_HI;
            TST_BOTH: return SRC_FAST_BOTH;
            default:  return SRC_SLOW;
        endcase
    endfunction

    function automatic logic is_arm(input logic [7:0] b);
        return (b == TST_LO) || (b == TST_HI) || (b == TST_BOTH);
    endfunction

endpackage

// File: rtl/wdt_key_reg.sv
module wdt_key_reg
    import keyed_wdt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic       restart,
    output period_e    period_q
);

    key_dec_t dec;

    always_comb begin
        dec     = decode_key(wr_data);
        restart = wr_en && dec.hit;
    end

    // Only power-on reset restores the default period
    always_ff @(posedge clk) begin
        if (rst)
            period_q <= PER_2S;
        else if (restart)
            period_q <= dec.period;
    end

    a_r3_bad_key_keeps_period: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !decode_key(wr_data).hit) |=> $stable(period_q));

endmodule

// File: rtl/wdt_test_ctrl.sv
module wdt_test_ctrl
    import keyed_wdt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output src_e       src_q,
    output logic       disabled_q
);

    logic armed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            src_q      <= SRC_SLOW;
            disabled_q <= 1'b0;
            armed_q    <= 1'b0;
        end else if (wr_en) begin
            src_q      <= decode_src(wr_data);
            disabled_q <= (wr_data == TST_OFF) && armed_q;
            armed_q    <= is_arm(wr_data);
        end
    end

    // R8: entering the stopped state needs an arming write just before
    a_r8_off_needs_arm: assert property (@(posedge clk) disable iff (rst)
        $rose(disabled_q) |-> $past(armed_q));

    // R9: any non-stop test write leaves the watchdog running
    a_r9_reenable: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_data != TST_OFF) |=> !disabled_q);

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
    import keyed_wdt_pkg::*;
#(
    parameter int CNT_W     = 17,
    parameter int LO_W      = 8,
    parameter int BASE_TERM = 8192
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    slow_tick,
    input  src_e    src,
    input  logic    run_en,
    input  logic    restart,
    input  period_e period,
    output logic    wdt_pulse,
    output logic    rst_req
);

    localparam int HI_W = CNT_W - LO_W;
    localparam logic [CNT_W-1:0] BASE_V = CNT_W'(BASE_TERM);

    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] count_nxt;
    logic [CNT_W-1:0] term;
    logic [LO_W-1:0]  lo;
    logic [HI_W-1:0]  hi;
    logic             lo_adv;
    logic             hi_adv;
    logic             expire;

    always_comb begin
        lo     = count_q[LO_W-1:0];
        hi     = count_q[CNT_W-1:LO_W];
        term   = BASE_V << period;
        lo_adv = (src == SRC_FAST_LO || src == SRC_FAST_BOTH) ? 1'b1 : slow_tick;
        if (src == SRC_FAST_HI || src == SRC_FAST_BOTH)
            hi_adv = 1'b1;
        else
            hi_adv = lo_adv && (&lo);
        count_nxt = {hi + HI_W'(hi_adv), lo + LO_W'(lo_adv)};
        expire    = run_en && !restart && (count_nxt >= term);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q   <= '0;
            rst_req   <= 1'b0;
            wdt_pulse <= 1'b0;
        end else begin
            rst_req <= expire;
            if (restart || expire)
                count_q <= '0;
            else if (run_en)
                count_q <= count_nxt;
            if (expire)
                wdt_pulse <= 1'b1;
            else if (slow_tick)
                wdt_pulse <= 1'b0;
        end
    end

    a_r2_restart_clears: assert property (@(posedge clk) disable iff (rst)
        restart |=> (count_q == '0));

    a_r4_below_term: assert property (@(posedge clk) disable iff (rst)
        count_q < term);

    a_r4_req_one_cycle: assert property (@(posedge clk) disable iff (rst)
        rst_req |=> !rst_req);

    a_r5_pulse_with_req: assert property (@(posedge clk) disable iff (rst)
        rst_req |-> wdt_pulse);

    a_r8_hold_when_off: assert property (@(posedge clk) disable iff (rst)
        (!run_en && !restart) |=> $stable(count_q));

endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
    import keyed_wdt_pkg::*;
#(
    parameter int CNT_W     = 17,
    parameter int LO_W      = 8,
    parameter int BASE_TERM = 8192
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       slow_tick,
    input  logic       wr_en,
    input  logic       wr_sel,
    input  logic [7:0] wr_data,
    output logic       wdt_pulse,
    output logic       rst_req
);

    logic    ctrl_we;
    logic    test_we;
    logic    restart;
    period_e period;
    src_e    src;
    logic    disabled;

    assign ctrl_we = wr_en && !wr_sel;
    assign test_we = wr_en && wr_sel;

    wdt_key_reg u_key (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (ctrl_we),
        .wr_data  (wr_data),
        .restart  (restart),
        .period_q (period)
    );

    wdt_test_ctrl u_test (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (test_we),
        .wr_data    (wr_data),
        .src_q      (src),
        .disabled_q (disabled)
    );

    wdt_counter #(
        .CNT_W     (CNT_W),
        .LO_W      (LO_W),
        .BASE_TERM (BASE_TERM)
    ) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .slow_tick (slow_tick),
        .src       (src),
        .run_en    (!disabled),
        .restart   (restart),
        .period    (period),
        .wdt_pulse (wdt_pulse),
        .rst_req   (rst_req)
    );

endmodule

// File: tb/sim_keyed_wdt.sv
module sim_keyed_wdt;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       slow_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_sel = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       wdt_pulse;
    logic       rst_req;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int c0 = 0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    keyed_wdt u0 (
        .clk       (clk),
        .rst       (rst),
        .slow_tick (slow_tick),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .wdt_pulse (wdt_pulse),
        .rst_req   (rst_req)
    );

    // {test code, key, tick level, expected edges to reset request}
    localparam logic [40:0] VEC [0:6] = '{
        {8'h52, 8'h5A, 1'b0, 24'd256},
        {8'h52, 8'h57, 1'b0, 24'd128},
        {8'h53, 8'h53, 1'b0, 24'd32},
        {8'h53, 8'h5A, 1'b0, 24'd256},
        {8'h53, 8'h59, 1'b0, 24'd64},
        {8'h51, 8'h59, 1'b0, 24'd16384},
        {8'h00, 8'h53, 1'b1, 24'd8192}
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(posedge clk); #1;
        c0 = cyc;
        wr_en = 1'b0;
    endtask

    // edges from c0 until rst_req is seen, or -1 after lim edges
    task automatic wait_req(input int lim, output int n);
        n = -1;
        for (int i = 0; i < lim; i++) begin
            @(posedge clk); #1;
            if (rst_req) begin
                n = cyc - c0;
                break;
            end
        end
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        check("R1 pulse after reset", int'(wdt_pulse), 0);
        check("R1 req after reset", int'(rst_req), 0);
        // R1: default 2 s period, count zero; fast upper part gives 256 edges
        wr(1'b1, 8'h52);
        wait_req(1000, n);
        check("R1 default period", n, 256);

        // R2 R6 R7: table of sources and keys
        foreach (VEC[k]) begin
            slow_tick = VEC[k][24];
            wr(1'b1, VEC[k][40:33]);
            wr(1'b0, VEC[k][32:25]);
            wait_req(20000, n);
            check("R2 R6 R7 vector interval", n, int'(VEC[k][23:0]));
        end

        // R4: request lasts one cycle; same period repeats from zero
        c0 = cyc;
        @(posedge clk); #1;
        check("R4 req one cycle", int'(rst_req), 0);
        check("R5 pulse one tick at full tick rate", int'(wdt_pulse), 0);
        wait_req(10000, n);
        check("R4 second interval", n, 8192);

        // R3: non-key byte mid-count changes nothing
        wr(1'b0, 8'h53);
        n = c0;
        repeat (100) @(posedge clk);
        wr(1'b0, 8'hA5);
        c0 = n;
        wait_req(10000, n);
        check("R3 bad key ignored", n, 8192);

        // R5: pulse held until next slow tick
        slow_tick = 1'b0;
        wr(1'b1, 8'h52);
        wr(1'b0, 8'h57);
        wait_req(1000, n);
        check("R5 interval", n, 128);
        check("R5 pulse rises with req", int'(wdt_pulse), 1);
        repeat (5) @(posedge clk);
        #1 check("R5 pulse held without tick", int'(wdt_pulse), 1);
        slow_tick = 1'b1;
        @(posedge clk); #1;
        slow_tick = 1'b0;
        check("R5 pulse cleared by tick", int'(wdt_pulse), 0);

        // R7: normal source with tick low never advances
        wr(1'b1, 8'h77);
        wr(1'b0, 8'h53);
        wait_req(300, n);
        check("R7 no tick no count", n, -1);

        // R8: armed stop, key still clears, no timeout
        wr(1'b1, 8'h53);
        wr(1'b1, 8'h54);
        wr(1'b0, 8'h53);
        slow_tick = 1'b1;
        wait_req(9000, n);
        check("R8 stopped no timeout", n, -1);
        // R9: other test write restarts from held zero
        wr(1'b1, 8'h00);
        wait_req(10000, n);
        check("R9 re-enabled interval", n, 8192);

        // R8: 0x54 not directly after an arming code does not stop
        wr(1'b1, 8'h51);
        wr(1'b1, 8'h00);
        wr(1'b1, 8'h54);
        wr(1'b0, 8'h53);
        wait_req(10000, n);
        check("R8 unarmed stop ignored", n, 8192);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule